// File: doc/BRIEF.md
# Five-Bit ROM Bank Controller

This block sits on a cartridge's host bus and turns writes aimed at the read-only ROM region into bank selection. It only has three address lines: A15, A14 and A13. It only has five data lines: D4 to D0. So it decodes each register over a whole 8 KiB span, and it never sees the top three bits of a written byte. It holds two registers. One is a five-bit low bank number. The other is a two-bit high bank number that lets ROMs above 4 Mbit reach their upper banks.

On the read side, the block drives the upper ROM address lines from the address lines it sees. The fixed window at the bottom of the map always gets bank 0. The switchable window gets the high bank bits followed by the low bank number. A low number of zero is replaced by one before it reaches the pins. This test uses only the five bits the controller holds, and the block has no idea how large the ROM is. A small ROM simply leaves the top bank lines unconnected, so a value such as 16 on a 16-bank ROM still wraps around to bank 0.

Top module: `rom_bank_ctl`

## Requirements
- R1: After reset, `lo_bank` is 1 and `hi_bank` is 0. With the address lines in the switchable window, `bank_lines` then reads 1.
- R2: On a clock edge with `bus_wr` high and `bus_a` = 3'b001 (host addresses 0x2000-0x3FFF), `lo_bank` takes the value of `bus_d`.
- R3: On a clock edge with `bus_wr` high and `bus_a` = 3'b010 (host addresses 0x4000-0x5FFF), `hi_bank` takes `bus_d[1:0]`.
- R4: A write with `bus_a` equal to 3'b000, 3'b011 or any 3'b1xx changes neither register. A clock edge without `bus_wr` changes neither register.
- R5: While `bus_a[2:1]` is not 2'b01 (fixed window, or A15 high), `bank_lines` is 0.
- R6: While `bus_a[2:1]` is 2'b01, `bank_lines` equals {`hi_bank`, L}. L is `lo_bank`, except that L is 1 when `lo_bank` is 0. This substitution applies whatever `hi_bank` holds.
- R7: A host byte of 0x20 is seen as 0 on the five data lines. It loads `lo_bank` with 0 and selects low bank number 1.
- R8: A nonzero five-bit value is never substituted, even when a small ROM wraps it onto bank 0. A value of 16 drives `bank_lines` = 16 (bank 0 on a 16-bank ROM). A value of 8 drives `bank_lines` = 8 (bank 0 on an 8-bank ROM).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe from the host |
| bus_a | input | 3 | Host address lines A15, A14, A13 (bit 2 = A15) |
| bus_d | input | 5 | Host data lines D4..D0 |
| bank_lines | output | 7 | Upper ROM address lines: {high bank, low bank after substitution} |
| lo_bank | output | 5 | Low bank register as written |
| hi_bank | output | 2 | High bank register |

## Verification
The bench aims at the substitution boundary in three cases: a zero written directly, a byte of 0x20 whose set bit falls off the data lines, and zero combined with a nonzero high bank. A design that tested the full byte, or the combined seven-bit bank, would drive bank 0 in some of these cases. Mirrored writes are placed at the very edges of their 8 KiB spans. Writes to the neighbouring spans and to A15-high addresses then show whether a wider or narrower decode picks up stray writes. Values 16 and 8 with a zero high bank confirm that the block does not wrap to bank 0 and then "correct" it to 1. That error would make a small ROM map the wrong bank.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

   // which register a decoded write targets
   typedef enum logic [1:0] {
      WT_NONE = 2'd0,
      WT_LOW  = 2'd1,
      WT_HIGH = 2'd2
   } wtarget_e;

   // three-line address codes (A15, A14, A13)
   localparam logic [2:0] SPAN_LOW  = 3'b001;
   localparam logic [2:0] SPAN_HIGH = 3'b010;
   localparam logic [1:0] WIN_SWITCH = 2'b01;

endpackage

// File: rtl/bank_decode.sv
module bank_decode
   import rbank_pkg::*;
(
   input  logic       wr,
   input  logic [2:0] a_hi,
   output wtarget_e   target,
   output logic       in_switch
);

   always_comb begin
      target = WT_NONE;
      if (wr) begin
         unique case (a_hi)
            SPAN_LOW:  target = WT_LOW;
            SPAN_HIGH: target = WT_HIGH;
            default:   target = WT_NONE;
         endcase
      end
   end

   assign in_switch = (a_hi[2:1] == WIN_SWITCH);

endmodule

// File: rtl/bank_field.sv
module bank_field #(
   parameter int unsigned    W       = 5,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("bank_field: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/bank_map.sv
module bank_map #(
   parameter int unsigned LOW_W    = 5,
   parameter int unsigned HIGH_W   = 2,
   parameter bit          ZERO_FIX = 1'b1,
   localparam int unsigned BANK_W  = LOW_W + HIGH_W
) (
   input  logic              in_switch,
   input  logic [LOW_W-1:0]  lo_q,
   input  logic [HIGH_W-1:0] hi_q,
   output logic [BANK_W-1:0] bank
);

   logic [LOW_W-1:0] lo_eff;

   generate
      if (ZERO_FIX) begin : g_subst
         // the zero test sees only the low field, never the high bits
         always_comb begin
            lo_eff = lo_q;
            if (lo_q == '0)
               lo_eff = LOW_W'(1);
         end
      end else begin : g_plain
         assign lo_eff = lo_q;
      end
   endgenerate

   assign bank = in_switch ? {hi_q, lo_eff} : '0;

endmodule

// File: rtl/rom_bank_ctl.sv
module rom_bank_ctl
   import rbank_pkg::*;
#(
   parameter int unsigned LOW_W    = 5,
   parameter int unsigned HIGH_W   = 2,
   parameter bit          ZERO_FIX = 1'b1,
   localparam int unsigned BANK_W  = LOW_W + HIGH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_a,
   input  logic [LOW_W-1:0]  bus_d,
   output logic [BANK_W-1:0] bank_lines,
   output logic [LOW_W-1:0]  lo_bank,
   output logic [HIGH_W-1:0] hi_bank
);

   generate
      if (HIGH_W < 1 || HIGH_W > LOW_W) begin : g_bad_high
         $error("rom_bank_ctl: HIGH_W must be 1..LOW_W");
      end
   endgenerate

   wtarget_e target;
   logic     in_switch;

   bank_decode u_dec (
      .wr        (bus_wr),
      .a_hi      (bus_a),
      .target    (target),
      .in_switch (in_switch)
   );

   bank_field #(.W(LOW_W), .RST_VAL(LOW_W'(1))) u_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (target == WT_LOW),
      .d     (bus_d),
      .q     (lo_bank)
   );

   bank_field #(.W(HIGH_W), .RST_VAL('0)) u_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (target == WT_HIGH),
      .d     (bus_d[HIGH_W-1:0]),
      .q     (hi_bank)
   );

   bank_map #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .ZERO_FIX(ZERO_FIX)) u_map (
      .in_switch (in_switch),
      .lo_q      (lo_bank),
      .hi_q      (hi_bank),
      .bank      (bank_lines)
   );

endmodule

// File: rtl/rom_bank_ctl_chk.sv
module rom_bank_ctl_chk #(
   parameter int unsigned LOW_W  = 5,
   parameter int unsigned HIGH_W = 2,
   localparam int unsigned BANK_W = LOW_W + HIGH_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [2:0]        bus_a,
   input logic [LOW_W-1:0]  bus_d,
   input logic [BANK_W-1:0] bank_lines,
   input logic [LOW_W-1:0]  lo_bank,
   input logic [HIGH_W-1:0] hi_bank
);

   // R2
   lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_a == 3'b001) |=> (lo_bank == $past(bus_d)));

   // R3
   hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_a == 3'b010) |=> (hi_bank == $past(bus_d[HIGH_W-1:0])));

   // R4
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_a == 3'b001) |=> $stable(lo_bank));

   // R4
   hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_a == 3'b010) |=> $stable(hi_bank));

   // R5
   fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_a[2:1] != 2'b01) |-> (bank_lines == '0));

   // R6
   never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_a[2:1] == 2'b01) |-> (bank_lines[LOW_W-1:0] != '0));

   // R6
   high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_a[2:1] == 2'b01) |-> (bank_lines[BANK_W-1:LOW_W] == hi_bank));

endmodule

bind rom_bank_ctl rom_bank_ctl_chk #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_chk (.*);

// File: tb/sim_rom_bank_ctl.sv
module sim_rom_bank_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_a = 3'b000;
   logic [4:0] bus_d = 5'd0;
   logic [6:0] bank_lines;
   logic [4:0] lo_bank;
   logic [1:0] hi_bank;

   int n_chk = 0;
   int n_bad = 0;
   logic [4:0] m_lo = 5'd1;
   logic [1:0] m_hi = 2'd0;

   always #4 clk = ~clk;   // 125 MHz

   rom_bank_ctl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a(bus_a),
      .bus_d(bus_d), .bank_lines(bank_lines), .lo_bank(lo_bank),
      .hi_bank(hi_bank)
   );

   // {host address[15:0], host byte[7:0]}
   localparam int NV = 12;
   localparam logic [23:0] VEC [NV] = '{
      24'h2100_05, 24'h3FFF_20, 24'h4000_03, 24'h5ABC_FE,
      24'h0000_0A, 24'h6000_01, 24'hA000_1F, 24'h3000_E7,
      24'h1FFF_11, 24'h2000_00, 24'hFFFF_09, 24'h5FFF_01
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [15:0] addr, input logic [7:0] b);
      @(negedge clk);
      bus_a  = addr[15:13];
      bus_d  = b[4:0];
      bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (addr[15:13] == 3'b001) m_lo = b[4:0];
      else if (addr[15:13] == 3'b010) m_hi = b[1:0];
   endtask

   function automatic int exp_win();
      return {m_hi, (m_lo == 5'd0) ? 5'd1 : m_lo};
   endfunction

   task automatic read_bank(input logic [2:0] a, output int v);
      @(negedge clk);
      bus_a = a;
      #1 v = int'(bank_lines);
   endtask

   logic done = 1'b0;

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      chk("R1 lo", int'(lo_bank), 1);
      chk("R1 hi", int'(hi_bank), 0);
      read_bank(3'b010, v);
      chk("R1 window", v, 1);

      for (int i = 0; i < NV; i++) begin
         host_write(VEC[i][23:8], VEC[i][7:0]);
         #1;
         chk("R2/R4 lo", int'(lo_bank), int'(m_lo));
         chk("R3/R4 hi", int'(hi_bank), int'(m_hi));
         read_bank(3'b011, v);
         chk("R6 window", v, exp_win());
         read_bank(3'b001, v);
         chk("R5 fixed", v, 0);
         read_bank(3'b100, v);
         chk("R5 a15", v, 0);
      end

      // R7: byte 0x20 loses bit 5 and becomes zero, substituted with 1
      host_write(16'h4000, 8'h00);
      host_write(16'h2000, 8'h20);
      #1 chk("R7 lo", int'(lo_bank), 0);
      read_bank(3'b010, v);
      chk("R7 window", v, 1);

      // R6: zero substitution with nonzero high bank
      host_write(16'h4000, 8'h02);
      read_bank(3'b011, v);
      chk("R6 high+zero", v, 65);

      // R8: 16 on a 16-bank ROM wraps to bank 0, no substitution
      host_write(16'h4000, 8'h00);
      host_write(16'h2000, 8'h10);
      read_bank(3'b010, v);
      chk("R8 sixteen", v, 16);
      chk("R8 rom16 bank", v % 16, 0);
      host_write(16'h2000, 8'h08);
      read_bank(3'b010, v);
      chk("R8 eight", v, 8);
      chk("R8 rom8 bank", v % 8, 0);

      // R4: strobe low leaves registers alone
      @(negedge clk);
      bus_a = 3'b001; bus_d = 5'd3; bus_wr = 1'b0;
      @(negedge clk);
      #1 chk("R4 no strobe", int'(lo_bank), 8);

      // R1: reset again mid-run
      rst_n = 1'b0;
      #1;
      chk("R1 re-reset lo", int'(lo_bank), 1);
      chk("R1 re-reset hi", int'(hi_bank), 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule